// File: doc/BRIEF.md
# Serial Bus Pause Controller

This block sits between the pins of a serial memory slave and its command engine and decides when a transaction is paused. The host pulls the active-low pause input low to suspend a transfer part way through. The block then stops passing serial clock edges and input bits on to the engine. Because the engine sees no edges, its bit counters and shift registers keep their place. When the host releases the pause, the transfer carries on from where it stopped.

The pins are sampled on the block's system clock `clk`, and the block assumes they are already synchronous to it. A pause starts or ends only while the serial clock is low. If the pause input changes while the serial clock is high, the change takes effect at the next falling edge of the serial clock. The output driver is an exception: its enable drops in the same cycle that the pause input goes low, whatever the level of the serial clock. Deselecting the slave clears the pause together with the rest of the transaction state.

Top module: `spi_pause_ctrl`

## Requirements
- R1: After reset, `paused`, `sck_rise_en`, `sck_fall_en` and `si_bit` are all 0.
- R2: While selected and not paused, if `hold_n` is 0 and `sck` is 0 in a cycle, `paused` is 1 in the next cycle.
- R3: If `hold_n` goes low while `sck` is 1, `paused` stays 0 until `sck` falls. In the cycle where `sck` falls with `hold_n` still low, `sck_fall_en` stays 0, and `paused` is 1 one cycle later.
- R4: If `hold_n` goes low and then returns high while `sck` stays 1, no pause ever starts.
- R5: While paused, if `hold_n` is 1 and `sck` is 0 in a cycle, `paused` is 0 in the next cycle.
- R6: While paused, if `hold_n` returns high while `sck` is 1, `paused` stays 1 until the cycle after `sck` next falls.
- R7: While `paused` is 1, `sck_rise_en` and `sck_fall_en` are 0 and `si_bit` keeps its value.
- R8: `so_oe` is 0 in any cycle where `hold_n` is 0, `cs_n` is 1 or `paused` is 1. It is 1 otherwise. It depends on `hold_n` directly, with no register in between.
- R9: If `cs_n` is 1 in a cycle, `paused` is 0 in the next cycle.
- R10: While selected and not paused, `sck_rise_en` is 1 in the first cycle in which `sck` reads 1 after reading 0. `si_bit` loads `si` at the end of that cycle. `sck_fall_en` is 1 in the first cycle in which `sck` reads 0 after reading 1, provided `hold_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low slave select |
| sck | input | 1 | Serial clock level, sampled on clk |
| hold_n | input | 1 | Active-low pause request |
| si | input | 1 | Serial data input |
| paused | output | 1 | Pause is in force; the command engine freezes |
| so_oe | output | 1 | Output driver enable; 0 means high impedance |
| sck_rise_en | output | 1 | Gated rising-edge strobe for the engine |
| sck_fall_en | output | 1 | Gated falling-edge strobe for the engine |
| si_bit | output | 1 | Last input bit taken on a gated rising edge |

## Verification
The bench targets pause requests that arrive while the serial clock is high. A design that acted on the level alone would pause at once, and one that ignored the deferral would never pause. A release made while the clock is high is checked the same way: a design that resumed early would let the following edges reach the engine. Clock edges and input bits sent during a pause must leave the strobes and `si_bit` unchanged, or the engine would lose its bit position. The bench also checks that the driver enable falls in the same cycle as the pause request. It finishes with deselection in the middle of a pause, which must clear the pause.

// File: rtl/spi_pause_ctrl.sv
module spi_pause_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic hold_n,
  input  logic si,
  output logic paused,
  output logic so_oe,
  output logic sck_rise_en,
  output logic sck_fall_en,
  output logic si_bit
);

  logic sck_q;
  logic sel;
  logic sck_low;
  logic enter_ok;
  logic leave_ok;
  logic paused_nx;

  assign sel      = ~cs_n;
  assign sck_low  = ~sck;
  assign enter_ok = ~hold_n & sck_low;
  assign leave_ok = hold_n & sck_low;

  always_comb begin
    if (!sel)
      paused_nx = 1'b0;
    else if (paused)
      paused_nx = ~leave_ok;
    else
      paused_nx = enter_ok;
  end

  assign sck_rise_en = sel & ~paused & sck & ~sck_q;
  assign sck_fall_en = sel & ~paused & hold_n & sck_low & sck_q;
  assign so_oe       = sel & hold_n & ~paused;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= 1'b0;
      paused <= 1'b0;
      si_bit <= 1'b0;
    end else begin
      sck_q  <= sck;
      paused <= paused_nx;
      if (sck_rise_en)
        si_bit <= si;
    end
  end

endmodule

// File: rtl/spi_pause_ctrl_chk.sv
module spi_pause_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sck,
  input logic hold_n,
  input logic paused,
  input logic so_oe,
  input logic sck_rise_en,
  input logic sck_fall_en,
  input logic si_bit
);

  a_r2_enter_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !paused && !hold_n && !sck) |=> paused);

  a_r4_no_enter_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!paused && sck) |=> !paused);

  a_r5_release_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && paused && hold_n && !sck) |=> !paused);

  a_r6_stay_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && paused && sck) |=> paused);

  a_r7_no_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    paused |-> (!sck_rise_en && !sck_fall_en));

  a_r7_si_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    paused |=> $stable(si_bit));

  a_r8_oe_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_n || cs_n) |-> !so_oe);

  a_r9_cs_clear: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !paused);

endmodule

bind spi_pause_ctrl spi_pause_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .hold_n(hold_n),
  .paused(paused), .so_oe(so_oe), .sck_rise_en(sck_rise_en),
  .sck_fall_en(sck_fall_en), .si_bit(si_bit)
);

// File: tb/tb_spi_pause_ctrl.sv
module tb_spi_pause_ctrl;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, hold_n = 1'b1, si = 1'b0;
  logic paused, so_oe, sck_rise_en, sck_fall_en, si_bit;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic m_p = 1'b0, m_sckq = 1'b0, m_si = 1'b0;

  always #4 clk = ~clk;

  spi_pause_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .hold_n(hold_n),
    .si(si), .paused(paused), .so_oe(so_oe), .sck_rise_en(sck_rise_en),
    .sck_fall_en(sck_fall_en), .si_bit(si_bit)
  );

  function automatic logic exp_rise();
    return !cs_n && !m_p && sck && !m_sckq;
  endfunction

  function automatic logic exp_fall();
    return !cs_n && !m_p && hold_n && !sck && m_sckq;
  endfunction

  function automatic logic exp_oe();
    return !cs_n && hold_n && !m_p;
  endfunction

  function automatic logic exp_next_p();
    if (cs_n) return 1'b0;
    if (m_p) return !(hold_n && !sck);
    return !hold_n && !sck;
  endfunction

  task automatic chk(string tag, string what, logic got, logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s got=%0b exp=%0b at %0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic step(string tag, logic c, logic k, logic h, logic d);
    logic np, nsi;
    @(negedge clk);
    cs_n = c; sck = k; hold_n = h; si = d;
    #2;
    chk(tag, "paused", paused, m_p);
    chk(tag, "so_oe", so_oe, exp_oe());
    chk(tag, "rise", sck_rise_en, exp_rise());
    chk(tag, "fall", sck_fall_en, exp_fall());
    chk(tag, "si_bit", si_bit, m_si);
    np = exp_next_p();
    nsi = exp_rise() ? si : m_si;
    @(posedge clk);
    m_p = np; m_si = nsi; m_sckq = sck;
  endtask

  initial begin
    #1500000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17));
    #1;
    chk("R1", "paused", paused, 1'b0);
    chk("R1", "rise", sck_rise_en, 1'b0);
    chk("R1", "fall", sck_fall_en, 1'b0);
    chk("R1", "si_bit", si_bit, 1'b0);
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;

    step("R1", 1, 0, 1, 0);
    step("R10", 0, 0, 1, 1);
    step("R10", 0, 1, 1, 1);
    step("R10", 0, 1, 1, 0);
    step("R10", 0, 0, 1, 0);
    // R3: request while clock high, deferred to falling edge
    step("R8", 0, 1, 1, 0);
    step("R8", 0, 1, 0, 0);
    step("R3", 0, 1, 0, 0);
    step("R3", 0, 0, 0, 0);
    step("R3", 0, 0, 0, 0);
    chk("R3", "paused_port", paused, 1'b1);
    // R7: activity ignored while paused
    step("R7", 0, 1, 0, 1);
    step("R7", 0, 0, 0, 1);
    step("R7", 0, 1, 0, 1);
    chk("R7", "si_hold", si_bit, 1'b0);
    // R6: release while clock high waits for falling edge
    step("R6", 0, 1, 1, 1);
    step("R6", 0, 1, 1, 1);
    chk("R6", "still", paused, 1'b1);
    step("R6", 0, 0, 1, 1);
    step("R6", 0, 0, 1, 1);
    chk("R6", "cleared", paused, 1'b0);
    // R4: request withdrawn while clock high
    step("R4", 0, 1, 1, 0);
    step("R4", 0, 1, 0, 0);
    step("R4", 0, 1, 1, 0);
    step("R4", 0, 0, 1, 0);
    step("R4", 0, 0, 1, 0);
    chk("R4", "none", paused, 1'b0);
    // R2 and R5
    step("R2", 0, 0, 0, 0);
    step("R2", 0, 0, 0, 0);
    chk("R2", "entered", paused, 1'b1);
    step("R5", 0, 0, 1, 0);
    step("R5", 0, 0, 1, 0);
    chk("R5", "left", paused, 1'b0);
    // R9: deselect during pause
    step("R9", 0, 0, 0, 0);
    step("R9", 0, 0, 0, 0);
    step("R9", 1, 0, 0, 0);
    step("R9", 1, 0, 0, 0);
    chk("R9", "cleared", paused, 1'b0);

    for (int i = 0; i < 4000; i++) begin
      logic c, k, h, d;
      c = ($urandom % 20) == 0;
      k = ($urandom % 3) == 0 ? ~sck : sck;
      h = ($urandom % 4) == 0 ? ~hold_n : hold_n;
      d = $urandom % 2;
      step("R10", c, k, h, d);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule